// File: doc/BRIEF.md
# Armed Overflow Error Monitor

This block watches two overflow indications from an arithmetic datapath, one from the cascade adder and one from the output selector, and turns them into sticky error flags. A flag can only capture an overflow after the host has armed it. Once captured, the flag stays set until the host clears it, and while any flag is set the block pulls a shared active-low error line. The line is modelled as an open-drain driver: a constant low data value plus an output enable, so several devices can share one interrupt wire.

The host writes a small control word. Each source has its own bit in that word. Writing 0 in a source's bit clears or disarms that source, and writing 1 arms it. Reading the word returns 1 in a source's bit only while that source holds a captured error. The cascade-adder flag cannot be cleared while the adder is still in overflow. An overflow that arrives after a clear and before the next arm is lost on purpose.

Top module: `ovf_err_monitor`

## Requirements
- R1: After reset both sources are disarmed, `rd_data_o` reads all zero and `err_oe_o` is low.
- R2: An overflow on a disarmed source is not recorded. Its read bit stays 0 and a later overflow, once armed, is needed to set it.
- R3: An overflow on an armed source latches it one clock later. The read bit for the cascade adder is bit 2 and the read bit for the selector is bit 1.
- R4: `err_n_o` is always 0. `err_oe_o` is 1 exactly while at least one source is latched.
- R5: Writing 0 in a latched source's bit clears it to disarmed one clock later. Writing 0 to an armed source disarms it.
- R6: Writing 0 to the latched cascade-adder source has no effect while `cas_ovf_i` is high in that cycle.
- R7: Writing 1 arms a disarmed source. Writing 1 to a latched source leaves it latched.
- R8: After a clear, an overflow that comes before the next arm write is not recorded. An overflow after that arm write is recorded.
- R9: Same-cycle rules. For an armed source, an overflow together with a write of 0 latches the source. For a disarmed source, an overflow together with a write of 1 arms it without latching.
- R10: The two sources are independent. Bit 0 of the write word is ignored, and bit 0 of the read word is always 0.
- R11: An armed source with no captured error reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_ovf_i | input | 1 | Cascade-adder overflow, high while in overflow |
| sel_ovf_i | input | 1 | Selector overflow pulse |
| wr_en_i | input | 1 | Host write strobe for the control word |
| wr_data_i | input | CTRL_W | Control word: bit 2 = cascade adder, bit 1 = selector; 0 clears, 1 arms |
| rd_data_o | output | CTRL_W | Read view: 1 in a source's bit while it is latched |
| err_n_o | output | 1 | Error line data value, constant low |
| err_oe_o | output | 1 | Error line drive enable, high while any source is latched |

## Verification
The bench puts each source into each of its three states and then applies every combination of write strobe, written bit and overflow for one cycle. A second overflow probe follows, which tells armed apart from disarmed even though both read 0. Several kinds of error would show up here. A design that ignores the arm state latches on a disarmed source. A design that lets the clear win over a simultaneous overflow on an armed source loses that error. A design that drops the overflow condition on the cascade adder clears it while the adder is still saturated. Directed sequences also cover the clear-then-arm gap, where an overflow must be lost, and crosstalk between the two bits, where one source's activity would show in the other.

// File: rtl/ovf_err_pkg.sv
package ovf_err_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_ARMED = 2'd1,
    SRC_HIT   = 2'd2
  } src_state_e;
endpackage

// File: rtl/ovf_src_cell.sv
module ovf_src_cell #(
  parameter bit HOLD_WHILE_ACTIVE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic hit_o,
  output logic armed_o
);
  import ovf_err_pkg::*;

  src_state_e st_q, st_d;
  logic clr_req, arm_req, clr_blocked;

  assign clr_req     = wr_en_i && !wr_bit_i;
  assign arm_req     = wr_en_i &&  wr_bit_i;
  // only the cascade adder keeps its flag while the overflow persists
  assign clr_blocked = HOLD_WHILE_ACTIVE && ovf_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SRC_IDLE:  if (arm_req) st_d = SRC_ARMED;
      SRC_ARMED: begin
        if (ovf_i)        st_d = SRC_HIT;   // arm existed first: capture wins
        else if (clr_req) st_d = SRC_IDLE;
      end
      SRC_HIT:   if (clr_req && !clr_blocked) st_d = SRC_IDLE;
      default:   st_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SRC_IDLE;
    else        st_q <= st_d;
  end

  assign hit_o   = (st_q == SRC_HIT);
  assign armed_o = (st_q == SRC_ARMED);
endmodule

// File: rtl/ovf_err_pin.sv
module ovf_err_pin #(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] hit_i,
  output logic            err_n_o,
  output logic            err_oe_o
);
  assign err_n_o  = 1'b0;
  assign err_oe_o = |hit_i;
endmodule

// File: rtl/ovf_err_monitor.sv
module ovf_err_monitor #(
  parameter int CTRL_W  = 3,
  parameter int CAS_BIT = 2,
  parameter int SEL_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_ovf_i,
  input  logic              sel_ovf_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              err_n_o,
  output logic              err_oe_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] ovf_vec;
  logic [NSRC-1:0] hit_vec;
  logic [NSRC-1:0] armed_vec;

  // index 0 = selector, index 1 = cascade adder
  assign ovf_vec = {cas_ovf_i, sel_ovf_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int POS = (g == 0) ? SEL_BIT : CAS_BIT;
    ovf_src_cell #(
      .HOLD_WHILE_ACTIVE(g == 1)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf_i    (ovf_vec[g]),
      .wr_en_i  (wr_en_i),
      .wr_bit_i (wr_data_i[POS]),
      .hit_o    (hit_vec[g]),
      .armed_o  (armed_vec[g])
    );
  end

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[SEL_BIT] = hit_vec[0];
    rd_data_o[CAS_BIT] = hit_vec[1];
  end

  ovf_err_pin #(.NSRC(NSRC)) u_pin (
    .hit_i    (hit_vec),
    .err_n_o  (err_n_o),
    .err_oe_o (err_oe_o)
  );
endmodule

// File: rtl/ovf_err_monitor_chk.sv
module ovf_err_monitor_chk #(
  parameter int CTRL_W  = 3,
  parameter int CAS_BIT = 2,
  parameter int SEL_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cas_ovf_i,
  input logic              sel_ovf_i,
  input logic              wr_en_i,
  input logic [CTRL_W-1:0] wr_data_i,
  input logic [CTRL_W-1:0] rd_data_o,
  input logic              err_n_o,
  input logic              err_oe_o
);
  a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data_o == '0));

  a_r4_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    err_n_o == 1'b0);

  a_r4_pin_enable: assert property (@(posedge clk) disable iff (!rst_n)
    err_oe_o == (|rd_data_o));

  a_r3_sel_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data_o[SEL_BIT] && sel_ovf_i == 1'b0) |=> !rd_data_o[SEL_BIT]);

  a_r3_cas_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data_o[CAS_BIT] && cas_ovf_i == 1'b0) |=> !rd_data_o[CAS_BIT]);

  a_r5_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[SEL_BIT] && wr_en_i && !wr_data_i[SEL_BIT]) |=> !rd_data_o[SEL_BIT]);

  a_r6_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[CAS_BIT] && cas_ovf_i) |=> rd_data_o[CAS_BIT]);

  a_r7_keep_on_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[SEL_BIT] && wr_en_i && wr_data_i[SEL_BIT]) |=> rd_data_o[SEL_BIT]);

  a_r10_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[0] == 1'b0);
endmodule

bind ovf_err_monitor ovf_err_monitor_chk #(
  .CTRL_W(CTRL_W), .CAS_BIT(CAS_BIT), .SEL_BIT(SEL_BIT)
) u_chk (.*);

// File: tb/sim_ovf_err_monitor.sv
`timescale 1ns/1ps
module sim_ovf_err_monitor;
  localparam int W = 3;
  localparam int CASB = 2;
  localparam int SELB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cas_ovf = 1'b0, sel_ovf = 1'b0, wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic err_n, err_oe;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  ovf_err_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cas_ovf_i(cas_ovf), .sel_ovf_i(sel_ovf),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .err_n_o(err_n), .err_oe_o(err_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; cas_ovf = 0; sel_ovf = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_inputs(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic set_ovf(input int src, input bit v);
    if (src == 1) cas_ovf = v; else sel_ovf = v;
  endtask

  // one cycle: drive at negedge, registers update at posedge, sample at next negedge
  task automatic step(input bit we, input logic [W-1:0] wd, input bit co, input bit so);
    wr_en = we; wr_data = wd; cas_ovf = co; sel_ovf = so;
    @(negedge clk);
    idle_inputs();
  endtask

  // reference state: 0 idle, 1 armed, 2 captured
  function automatic int ref_next(int st, bit we, bit wb, bit ov, bit is_cas);
    case (st)
      0: return (we && wb) ? 1 : 0;
      1: return ov ? 2 : ((we && !wb) ? 0 : 1);
      default: return (we && !wb && !(is_cas && ov)) ? 0 : 2;
    endcase
  endfunction

  function automatic string tag_of(int st, bit we, bit wb, bit ov, bit is_cas);
    if (st == 0) return (we && wb) ? (ov ? "R9" : "R7") : "R2";
    if (st == 1) return ov ? ((we && !wb) ? "R9" : "R3") : ((we && !wb) ? "R5" : "R11");
    if (is_cas && ov && we && !wb) return "R6";
    return (we && !wb) ? "R5" : "R7";
  endfunction

  task automatic run_case(input int src, input int st, input bit we, input bit wb, input bit ov);
    int tb, ob, ex;
    logic [W-1:0] wd;
    string tg;
    tb = (src == 1) ? CASB : SELB;
    ob = (src == 1) ? SELB : CASB;
    do_reset();
    if (st >= 1) begin wd = '0; wd[tb] = 1'b1; step(1, wd, 0, 0); end
    if (st == 2) step(0, '0, src == 1, src == 0);
    wd = '0; wd[tb] = wb; wd[ob] = 1'b1;
    wr_en = we; wr_data = wd; set_ovf(src, ov);
    @(negedge clk); idle_inputs();
    ex = ref_next(st, we, wb, ov, src == 1);
    tg = tag_of(st, we, wb, ov, src == 1);
    chk(rd_data[tb] == (ex == 2), tg, rd_data[tb], ex == 2);
    chk(rd_data[ob] == 1'b0, "R10", rd_data[ob], 0);
    chk(err_oe == (ex == 2), "R4", err_oe, ex == 2);
    chk(err_n == 1'b0, "R4", err_n, 0);
    // probe: a fresh overflow shows whether the source was still armed
    step(0, '0, src == 1, src == 0);
    chk(rd_data[tb] == (ex != 0), (ex == 0) ? "R2" : "R3", rd_data[tb], ex != 0);
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    do_reset();
    chk(rd_data == '0, "R1", rd_data, 0);
    chk(err_oe == 1'b0, "R1", err_oe, 0);

    for (int s = 0; s < 2; s++)
      for (int st = 0; st < 3; st++)
        for (int c = 0; c < 8; c++)
          run_case(s, st, c[2], c[1], c[0]);

    // R8: clear, overflow in the gap, arm, then overflow
    do_reset();
    step(1, 3'b010, 0, 0);
    step(0, '0, 0, 1);
    chk(rd_data == 3'b010, "R3", rd_data, 3'b010);
    step(1, 3'b000, 0, 0);
    step(0, '0, 0, 1);
    chk(rd_data == 3'b000, "R8", rd_data, 0);
    step(1, 3'b010, 0, 0);
    chk(rd_data == 3'b000, "R11", rd_data, 0);
    step(0, '0, 0, 1);
    chk(rd_data == 3'b010, "R8", rd_data, 3'b010);

    // R10: both captured, clear only selector; bit 0 of the write is ignored
    do_reset();
    step(1, 3'b111, 0, 0);
    step(0, '0, 1, 1);
    chk(rd_data == 3'b110, "R10", rd_data, 3'b110);
    step(1, 3'b101, 0, 0);
    chk(rd_data == 3'b100, "R10", rd_data, 3'b100);
    chk(err_oe == 1'b1, "R4", err_oe, 1);
    // R6: cascade clear held off while saturated, then takes effect
    step(1, 3'b001, 1, 0);
    chk(rd_data == 3'b100, "R6", rd_data, 3'b100);
    step(1, 3'b001, 0, 0);
    chk(rd_data == 3'b000, "R6", rd_data, 0);
    chk(err_oe == 1'b0, "R4", err_oe, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule